// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table that sits in ordinary memory. A requester hands over the virtual address, the base address of the top-level directory and a write flag. The walker then makes two word reads through a valid/ready request channel and a response-valid return channel. After that it reports the physical address or a fault code.

Addresses are split into a 10-bit directory index, a 10-bit table index and a 12-bit byte offset. Every table entry is 32 bits wide:

- Its upper 20 bits name a 4096-byte frame.
- Its lower 12 bits are flags. Flag bit 0 means the entry is present, and flag bit 1 means the entry is writable.

When a walk succeeds, the walker also sends out a refill record for a translation cache. The record holds the virtual page number, the frame number and the leaf flags. The walker serves one request at a time.

Top module: `pt_walker`

## Requirements
- R1: The first memory read goes to `req_dir_base + 4 * vaddr[31:22]`.
- R2: The second memory read goes to `{first_entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R3: A successful walk returns `rsp_paddr = {second_entry[31:12], vaddr[11:0]}` with fault code 0 (none).
- R4: If bit 0 of the first entry is clear, the walk ends with fault code 1 (page fault). No second read is issued.
- R5: If bit 0 of the second entry is clear, the walk ends with fault code 1 (page fault).
- R6: A write request fails with fault code 2 (protection fault) if bit 1 of a present entry is clear, at either level. A write stopped this way at the first level issues no second read. A read request ignores bit 1. When both bits are clear, the page fault wins.
- R7: `req_ready` is high when the walker is idle. It is low from the cycle after a request is accepted until the cycle after the response pulse.
- R8: `rsp_valid` is a one-cycle pulse. On any fault, `rsp_paddr` is 0.
- R9: `refill_valid` pulses together with `rsp_valid` only on success. With it come `refill_vpn = vaddr[31:12]`, `refill_pfn = second_entry[31:12]` and `refill_flags = second_entry[11:0]`.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and `mem_req_addr` does not change.
- R11: Virtual address 0x00403004 with directory base B first reads B+4. It then reads the first entry's frame plus 12, and keeps offset 4 in the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_dir_base | input | 32 | Byte address of the top-level directory |
| req_write | input | 1 | Request is a write access |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry word |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| refill_valid | output | 1 | Translation cache refill pulse |
| refill_vpn | output | 20 | Virtual page number |
| refill_pfn | output | 20 | Physical frame number |
| refill_flags | output | 12 | Flags of the leaf entry |

## Verification
The bound checker watches the handshake rules on every cycle:

- the busy window of `req_ready`
- the single-cycle response pulse
- the stability of a stalled memory request
- that refill appears only with a fault-free response
- that a faulting response carries a zero address
- that the returned offset and page number match the accepted address

Only the bench scenarios can show that the two read addresses and the final frame are formed correctly. The same holds for which level and which flag combination give which fault code, and for the second read being skipped after a first-level fault. The bench sweeps every combination of present and writable bits at both levels, for reads and for writes, across varied indices and memory stall lengths.

// File: rtl/ptw_pkg.sv
// Shared types for the page table walker.
// Assumes a 32-bit address split 10/10/12 and 32-bit entries.
package ptw_pkg;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 10;
    localparam int OFF_W  = 12;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
// Forms the byte address of the table entry to read at the current level.
// Assumes entries are 4 bytes and the second-level table is frame aligned.
module ptw_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic              second_lvl,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic [ADDR_W-OFF_W-1:0] tbl_frame,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int FRAME_W = ADDR_W - OFF_W;

    logic [IDX_W-1:0]  dir_idx;
    logic [IDX_W-1:0]  tbl_idx;
    logic [ADDR_W-1:0] dir_off;
    logic [ADDR_W-1:0] tbl_off;

    // Pick the index fields and scale them to byte offsets.
    always_comb begin
        dir_idx = vaddr[ADDR_W-1 -: IDX_W];
        tbl_idx = vaddr[OFF_W +: IDX_W];
        dir_off = ADDR_W'({dir_idx, 2'b00});
        tbl_off = ADDR_W'({tbl_idx, 2'b00});
    end

    // Choose directory slot or second-level slot.
    always_comb begin
        if (second_lvl)
            entry_addr = {tbl_frame, {OFF_W{1'b0}}} + tbl_off;
        else
            entry_addr = dir_base + dir_off;
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, FRAME_W[0]};
endmodule

// File: rtl/ptw_entry_check.sv
// Decides the fault outcome of one table entry.
// Assumes bit PRESENT_BIT marks present and bit WRITE_BIT marks writable.
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int ENTRY_W     = 32,
    parameter int PRESENT_BIT = 0,
    parameter int WRITE_BIT   = 1
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic               is_write,
    output fault_e             fault
);
    // Absent entries win over write protection.
    always_comb begin
        if (!entry[PRESENT_BIT])
            fault = FLT_PAGE;
        else if (is_write && !entry[WRITE_BIT])
            fault = FLT_PROT;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level table walker: accepts one translation at a time, reads the
// directory entry, then the leaf entry, and reports address or fault.
// Assumes memory returns exactly one response per accepted read.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_vaddr,
    input  logic [ADDR_W-1:0]     req_dir_base,
    input  logic                  req_write,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [ADDR_W-1:0]     mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [ADDR_W-1:0]     mem_rsp_data,
    output logic                  rsp_valid,
    output logic [ADDR_W-1:0]     rsp_paddr,
    output logic [1:0]            rsp_fault,
    output logic                  refill_valid,
    output logic [ADDR_W-OFF_W-1:0] refill_vpn,
    output logic [ADDR_W-OFF_W-1:0] refill_pfn,
    output logic [OFF_W-1:0]      refill_flags
);
    localparam int FRAME_W = ADDR_W - OFF_W;

    walk_st_e          st_q;
    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] base_q;
    logic              wr_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic [FRAME_W-1:0] pfn_q;
    logic [OFF_W-1:0]  flags_q;
    logic [ADDR_W-1:0] paddr_q;
    fault_e            fault_q;
    fault_e            entry_fault;

    ptw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) addr_i (
        .second_lvl (st_q == ST_L2_REQ),
        .vaddr      (va_q),
        .dir_base   (base_q),
        .tbl_frame  (tbl_frame_q),
        .entry_addr (mem_req_addr)
    );

    ptw_entry_check #(.ENTRY_W(ADDR_W)) chk_i (
        .entry    (mem_rsp_data),
        .is_write (wr_q),
        .fault    (entry_fault)
    );

    // Walk sequencing and capture of request and result fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            va_q        <= '0;
            base_q      <= '0;
            wr_q        <= 1'b0;
            tbl_frame_q <= '0;
            pfn_q       <= '0;
            flags_q     <= '0;
            paddr_q     <= '0;
            fault_q     <= FLT_NONE;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    base_q <= req_dir_base;
                    wr_q   <= req_write;
                    st_q   <= ST_L1_REQ;
                end
                ST_L1_REQ: if (mem_req_ready) st_q <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    if (entry_fault != FLT_NONE) begin
                        fault_q <= entry_fault;
                        paddr_q <= '0;
                        st_q    <= ST_DONE;
                    end else begin
                        tbl_frame_q <= mem_rsp_data[ADDR_W-1:OFF_W];
                        st_q        <= ST_L2_REQ;
                    end
                end
                ST_L2_REQ: if (mem_req_ready) st_q <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    fault_q <= entry_fault;
                    pfn_q   <= mem_rsp_data[ADDR_W-1:OFF_W];
                    flags_q <= mem_rsp_data[OFF_W-1:0];
                    paddr_q <= (entry_fault == FLT_NONE) ?
                               {mem_rsp_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
                    st_q    <= ST_DONE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from walk state and captured result.
    always_comb begin
        req_ready     = (st_q == ST_IDLE);
        mem_req_valid = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
        rsp_valid     = (st_q == ST_DONE);
        rsp_paddr     = paddr_q;
        rsp_fault     = fault_q;
        refill_valid  = (st_q == ST_DONE) && (fault_q == FLT_NONE);
        refill_vpn    = va_q[ADDR_W-1:OFF_W];
        refill_pfn    = pfn_q;
        refill_flags  = flags_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol checker for pt_walker; observes ports only, plus a copy of the
// accepted virtual address.
module pt_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [ADDR_W-1:0]     req_vaddr,
    input logic [ADDR_W-1:0]     req_dir_base,
    input logic                  req_write,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic [ADDR_W-1:0]     mem_req_addr,
    input logic                  mem_rsp_valid,
    input logic [ADDR_W-1:0]     mem_rsp_data,
    input logic                  rsp_valid,
    input logic [ADDR_W-1:0]     rsp_paddr,
    input logic [1:0]            rsp_fault,
    input logic                  refill_valid,
    input logic [ADDR_W-OFF_W-1:0] refill_vpn,
    input logic [ADDR_W-OFF_W-1:0] refill_pfn,
    input logic [OFF_W-1:0]      refill_flags
);
    logic [ADDR_W-1:0] seen_va;

    // Remember the address of the request in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_va <= '0;
        else if (req_valid && req_ready) seen_va <= req_vaddr;
    end

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_no_read_while_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && req_ready));
    assert_rsp_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_fault_zero_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
    assert_refill_only_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |-> (rsp_valid && rsp_fault == 2'd0));
    assert_refill_vpn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |-> (refill_vpn == seen_va[ADDR_W-1:OFF_W]));
    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[OFF_W-1:0] == seen_va[OFF_W-1:0]));
    assert_fault_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'd3));
    assert_mem_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    logic unused_ok;
    assign unused_ok = &{1'b0, req_dir_base, req_write, mem_rsp_valid, mem_rsp_data,
                         refill_pfn, refill_flags};
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) prot_chk_i (.*);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_dir_base = '0;
    logic        req_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        refill_valid;
    logic [19:0] refill_vpn;
    logic [19:0] refill_pfn;
    logic [11:0] refill_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pt_walker dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(input logic [31:0] e, input bit wr);
        if (!e[0]) return 2'd1;
        if (wr && !e[1]) return 2'd2;
        return 2'd0;
    endfunction

    // Serve one table read: check address, stall, accept, respond.
    task automatic serve(input logic [31:0] addr, input logic [31:0] data,
                         input int stall, input string req);
        chk(req, {31'd0, mem_req_valid}, 32'd1);
        chk(req, mem_req_addr, addr);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk("R10", {31'd0, mem_req_valid}, 32'd1);
            chk("R10", mem_req_addr, addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R10", {31'd0, mem_req_valid}, 32'd0);
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit wr,
                        input logic [31:0] e1, input logic [31:0] e2, input int stall,
                        input string tag);
        logic [31:0] a1, a2;
        logic [1:0]  ef;
        a1 = base + {20'd0, va[31:22], 2'b00};
        a2 = {e1[31:12], 12'd0} + {20'd0, va[21:12], 2'b00};
        @(negedge clk);
        chk("R7", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = va; req_dir_base = base; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7", {31'd0, req_ready}, 32'd0);
        serve(a1, e1, stall, tag == "R11" ? "R11" : "R1");
        ef = exp_fault(e1, wr);
        if (ef == 2'd0) begin
            serve(a2, e2, stall, tag == "R11" ? "R11" : "R2");
            ef = exp_fault(e2, wr);
            chk(e2[0] ? (wr ? "R6" : "R3") : "R5", {30'd0, rsp_fault}, {30'd0, ef});
        end else begin
            chk(e1[0] ? "R6" : "R4", {30'd0, rsp_fault}, {30'd0, ef});
            chk(e1[0] ? "R6" : "R4", {31'd0, mem_req_valid}, 32'd0);
        end
        chk("R8", {31'd0, rsp_valid}, 32'd1);
        if (ef == 2'd0) begin
            chk(tag == "R11" ? "R11" : "R3", rsp_paddr, {e2[31:12], va[11:0]});
            chk("R9", {31'd0, refill_valid}, 32'd1);
            chk("R9", {12'd0, refill_vpn}, {12'd0, va[31:12]});
            chk("R9", {12'd0, refill_pfn}, {12'd0, e2[31:12]});
            chk("R9", {20'd0, refill_flags}, {20'd0, e2[11:0]});
        end else begin
            chk("R8", rsp_paddr, 32'd0);
            chk("R9", {31'd0, refill_valid}, 32'd0);
        end
        @(negedge clk);
        chk("R8", {31'd0, rsp_valid}, 32'd0);
        chk("R7", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R7", {31'd0, req_ready}, 32'd1);
        chk("R8", {31'd0, rsp_valid}, 32'd0);
        chk("R10", {31'd0, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        // Worked example: dir index 1, table index 3, offset 4.
        walk(32'h0040_3004, 32'h0001_0000, 1'b0, 32'h0002_0003, 32'h0005_5003, 1, "R11");
        // Sweep all flag pairs at both levels for reads and writes.
        for (int it = 0; it < 64; it++) begin
            logic [9:0]  di, ti;
            logic [11:0] off;
            logic [31:0] e1, e2, va;
            bit wr;
            wr  = it[5];
            di  = 10'((it * 37) % 1024) ^ {it[0], 9'd0};
            ti  = 10'((it * 113 + 5) % 1024);
            off = 12'((it * 291) % 4096);
            va  = {di, ti, off};
            e1  = {20'h1_2000 ^ {10'd0, di}, 8'h5A, 2'b00, it[1:0]};
            e2  = {20'hA_B000 ^ {ti, 10'd0}, 8'hC3, 2'b10, it[3:2]};
            if (it[4]) e2[11:4] = 8'h0F;
            walk(va, 32'h0030_0000 + {18'd0, it[5:0], 8'd0}, wr, e1, e2, it % 3, "SW");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule